// File: doc/BRIEF.md
# Dual-Port RAM Bank Ownership and Mailbox Controller

This block sits beside a 32K x 16 dual-port RAM that a host processor (left port) and a DSP (right port) share. The RAM is split into four 8K-word banks, chosen by address bits 14:13. Bank 0 always belongs to the host and bank 1 always belongs to the DSP. Banks 2 and 3 are exchange banks that change hands. The DSP hands bank 2 over with one of its general-purpose output lines, and the host hands bank 3 over with one of its own control lines. The block turns both lines into one registered select bit per bank. In each select bit, 0 means the left port owns the bank and 1 means the right port owns it.

Each port's memory strobe, taken together with address bit 15, forms the RAM chip select. The decode is combinational, so an access needs no wait state. A port that touches a bank it does not own gets no chip select, and the block flags an ownership error. An active I/O strobe on a port turns the access into a mailbox access, and address bits 1:0 give the mailbox number. A mailbox write raises a pending flag for the other port. That port's interrupt stays high until it reads the same mailbox.

In the ping-pong exchange, the DSP first fills bank 2, gives it away and writes mailbox 2. The host fills bank 3, gives it away and writes mailbox 3. The DSP reads mailbox 3 to clear its interrupt, reads bank 3, writes its reply there and writes mailbox 3 again.

Top module: `dpram_xchg_ctrl`

## Requirements
- R1: While rst_n is low, bank_sel is 4'b0110 (bank 2 held by the right port, bank 3 by the left port), and both irq outputs and both own_err outputs are 0.
- R2: bank_sel[0] is always 0 and bank_sel[1] is always 1.
- R3: One cycle after a clock edge, bank_sel[2] equals the inverse of r_b2_give and bank_sel[3] equals l_b3_give, as sampled at that edge.
- R4: In the same cycle, a port's ram_cs is high exactly when its req is high, addr[15] is 1, its io is low, and bank_sel[addr[14:13]] equals the port's id (left 0, right 1).
- R5: While a port's io is high, its ram_cs is low whatever its req and addr are.
- R6: A memory access with req high, io low and addr[15]=1 to a bank that the port does not own drives that port's own_err high for exactly the following cycle.
- R7: A mailbox write (io=1, we=1, mailbox number addr[1:0]) by one port sets the other port's pending flag for that number, and the other port's irq is high from the next cycle.
- R8: A mailbox read (io=1, we=0) by a port clears only that port's pending flag for number addr[1:0]. Its irq falls once no flag remains set, and the other port's flags are left as they are.
- R9: When one port reads mailbox n in the same cycle that the other port writes mailbox n, the reader's flag n stays set.
- R10: An access with addr[15]=0 produces no ram_cs and no own_err on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_req | input | 1 | Host memory strobe, active high |
| l_io | input | 1 | Host I/O strobe; selects a mailbox access |
| l_we | input | 1 | Host write (1) or read (0) |
| l_addr | input | 16 | Host address |
| r_req | input | 1 | DSP memory strobe, active high |
| r_io | input | 1 | DSP I/O strobe; selects a mailbox access |
| r_we | input | 1 | DSP write (1) or read (0) |
| r_addr | input | 16 | DSP address |
| r_b2_give | input | 1 | DSP output line: 1 hands bank 2 to the host |
| l_b3_give | input | 1 | Host control line: 1 hands bank 3 to the DSP |
| bank_sel | output | 4 | Per-bank owner select, 0 = left, 1 = right |
| l_ram_cs | output | 1 | RAM chip select for the left port |
| r_ram_cs | output | 1 | RAM chip select for the right port |
| l_own_err | output | 1 | Left port touched a bank it does not own |
| r_own_err | output | 1 | Right port touched a bank it does not own |
| l_irq | output | 1 | Host interrupt, mailbox pending |
| r_irq | output | 1 | DSP interrupt, mailbox pending |

## Verification
The bench runs the full ping-pong exchange through a RAM model, so the data written on one side must show up on the other. A select that flipped the wrong way would expose stale or blocked data. It targets a read-clear of a mailbox in the same cycle as a write to that mailbox; a design that lets the clear win would lose a handoff interrupt. It combines the I/O strobe with the memory strobe and sends accesses to the lower half of the address space; a loose decode would then raise chip selects and corrupt local memory. It also reaches for exchange banks just after they change owner; a one-cycle lag in the ownership check would let a late access through or raise a spurious error.

// File: rtl/dxm_pkg.sv
package dxm_pkg;
  localparam int NPORT = 2;
  typedef enum logic {OWN_LEFT = 1'b0, OWN_RIGHT = 1'b1} owner_e;
endpackage

// File: rtl/dxm_own_reg.sv
module dxm_own_reg #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             r_b2_give,
  input  logic             l_b3_give,
  output logic [NBANK-1:0] bank_sel
);
  import dxm_pkg::*;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == 2 || b == 3) begin : g_xchg
      logic sel_q, sel_d, sel_en;
      localparam owner_e RST_OWN = (b == 2) ? OWN_RIGHT : OWN_LEFT;
      always_comb begin
        sel_d  = (b == 2) ? ~r_b2_give : l_b3_give;
        sel_en = (sel_d != sel_q);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= RST_OWN;
        else if (sel_en) sel_q <= sel_d;
      end
      assign bank_sel[b] = sel_q;
    end else begin : g_fixed
      assign bank_sel[b] = (b == 1) ? OWN_RIGHT : OWN_LEFT;
    end
  end
endmodule

// File: rtl/dxm_port_dec.sv
module dxm_port_dec #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int MB_W    = 2,
  parameter int PORT_ID = 0,
  localparam int NBANK  = 1 << BANK_W,
  localparam int NMB    = 1 << MB_W,
  localparam int BANK_LSB = ADDR_W - 1 - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              io,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_sel,
  output logic              ram_cs,
  output logic              own_err,
  output logic [NMB-1:0]    mb_wr,
  output logic [NMB-1:0]    mb_rd
);
  logic [BANK_W-1:0] bank;
  logic mem_hit, owned, blocked, err_q;
  logic addr_mid_unused;

  assign addr_mid_unused = ^addr[BANK_LSB-1:MB_W];

  always_comb begin
    bank    = addr[ADDR_W-2 -: BANK_W];
    mem_hit = req & addr[ADDR_W-1] & ~io;
    owned   = (bank_sel[bank] == PORT_ID[0]);
    ram_cs  = mem_hit & owned;
    blocked = mem_hit & ~owned;
    mb_wr   = '0;
    mb_rd   = '0;
    if (io) begin
      if (we) mb_wr[addr[MB_W-1:0]] = 1'b1;
      else    mb_rd[addr[MB_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= blocked;
  end
  assign own_err = err_q;
endmodule

// File: rtl/dxm_mailbox.sv
module dxm_mailbox #(
  parameter int MB_W = 2,
  localparam int NMB = 1 << MB_W,
  localparam int NPORT = dxm_pkg::NPORT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0][NMB-1:0] mb_wr,
  input  logic [NPORT-1:0][NMB-1:0] mb_rd,
  output logic [NPORT-1:0]          irq
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [NMB-1:0] pend_q, pend_d;
    logic pend_en;
    always_comb begin
      // a write from the peer outranks a clearing read by this port
      pend_d  = (pend_q & ~mb_rd[p]) | mb_wr[NPORT-1-p];
      pend_en = (pend_d != pend_q);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= '0;
      else if (pend_en) pend_q <= pend_d;
    end
    assign irq[p] = |pend_q;
  end
endmodule

// File: rtl/dpram_xchg_ctrl.sv
module dpram_xchg_ctrl #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  parameter int MB_W   = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_req,
  input  logic              l_io,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_req,
  input  logic              r_io,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_b2_give,
  input  logic              l_b3_give,
  output logic [NBANK-1:0]  bank_sel,
  output logic              l_ram_cs,
  output logic              r_ram_cs,
  output logic              l_own_err,
  output logic              r_own_err,
  output logic              l_irq,
  output logic              r_irq
);
  import dxm_pkg::*;
  localparam int NMB = 1 << MB_W;

  logic [NPORT-1:0]              req_v, io_v, we_v, cs_v, err_v, irq_v;
  logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
  logic [NPORT-1:0][NMB-1:0]     wr_v, rd_v;

  assign req_v  = {r_req, l_req};
  assign io_v   = {r_io, l_io};
  assign we_v   = {r_we, l_we};
  assign addr_v = {r_addr, l_addr};

  dxm_own_reg #(.BANK_W(BANK_W)) own_i (
    .clk(clk), .rst_n(rst_n), .r_b2_give(r_b2_give),
    .l_b3_give(l_b3_give), .bank_sel(bank_sel)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    dxm_port_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MB_W(MB_W), .PORT_ID(p)) dec_i (
      .clk(clk), .rst_n(rst_n), .req(req_v[p]), .io(io_v[p]), .we(we_v[p]),
      .addr(addr_v[p]), .bank_sel(bank_sel), .ram_cs(cs_v[p]),
      .own_err(err_v[p]), .mb_wr(wr_v[p]), .mb_rd(rd_v[p])
    );
  end

  dxm_mailbox #(.MB_W(MB_W)) mb_i (
    .clk(clk), .rst_n(rst_n), .mb_wr(wr_v), .mb_rd(rd_v), .irq(irq_v)
  );

  assign l_ram_cs  = cs_v[0];
  assign r_ram_cs  = cs_v[1];
  assign l_own_err = err_v[0];
  assign r_own_err = err_v[1];
  assign l_irq     = irq_v[0];
  assign r_irq     = irq_v[1];
endmodule

module dpram_xchg_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        l_req,
  input logic        l_io,
  input logic [15:0] l_addr,
  input logic        r_req,
  input logic        r_io,
  input logic        r_we,
  input logic [15:0] r_addr,
  input logic        l_b3_give,
  input logic [3:0]  bank_sel,
  input logic        l_ram_cs,
  input logic        r_ram_cs,
  input logic        l_own_err,
  input logic        l_irq
);
  assert_sel_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bank_sel[3] == $past(l_b3_give));
  assert_cs_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_ram_cs |-> bank_sel[r_addr[14:13]]);
  assert_io_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    l_io |-> !l_ram_cs);
  assert_blocked_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_req && l_addr[15] && !l_io && bank_sel[l_addr[14:13]]) |=> l_own_err);
  assert_mb_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_io && r_we) |=> l_irq);
  assert_low_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_addr[15] || !r_addr[15]) |-> !((!l_addr[15] && l_ram_cs) || (!r_addr[15] && r_ram_cs)));
  assert_no_cs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_req) |-> !r_ram_cs);
endmodule

bind dpram_xchg_ctrl dpram_xchg_ctrl_chk chk_i (.*);

// File: tb/dpram_xchg_ctrl_tb_top.sv
`timescale 1ns/1ps
module dpram_xchg_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic l_req, l_io, l_we, r_req, r_io, r_we, r_b2_give, l_b3_give;
  logic [15:0] l_addr, r_addr;
  logic [3:0] bank_sel;
  logic l_ram_cs, r_ram_cs, l_own_err, r_own_err, l_irq, r_irq;
  logic [15:0] l_wdata, r_wdata;

  int checks = 0, fails = 0;
  logic [3:0] m_sel, m_lp, m_rp;
  logic m_lerr, m_rerr;
  logic [15:0] ram [0:63];

  always #2.5 clk = ~clk;

  dpram_xchg_ctrl dut_i (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic exp_cs(logic q, logic io, logic [15:0] a, logic id);
    return q & a[15] & ~io & (m_sel[a[14:13]] == id);
  endfunction
  function automatic logic exp_blk(logic q, logic io, logic [15:0] a, logic id);
    return q & a[15] & ~io & (m_sel[a[14:13]] != id);
  endfunction
  function automatic logic [5:0] ridx(logic [15:0] a);
    return {a[14:13], a[3:0]};
  endfunction

  task automatic drv(input logic lq, lio, lwe, input logic [15:0] la,
                     input logic rq, rio, rwe, input logic [15:0] ra);
    l_req = lq; l_io = lio; l_we = lwe; l_addr = la;
    r_req = rq; r_io = rio; r_we = rwe; r_addr = ra;
  endtask

  // one bus cycle: inputs already applied after a falling edge
  task automatic step();
    logic [3:0] nlp, nrp;
    #1;
    check("R4 l_ram_cs", l_ram_cs, exp_cs(l_req, l_io, l_addr, 1'b0));
    check("R4 r_ram_cs", r_ram_cs, exp_cs(r_req, r_io, r_addr, 1'b1));
    if (!l_addr[15]) check("R10 l_ram_cs low half", l_ram_cs, 0);
    nlp = m_lp; nrp = m_rp;
    if (l_io && !l_we) nlp[l_addr[1:0]] = 1'b0;
    if (r_io && !r_we) nrp[r_addr[1:0]] = 1'b0;
    if (r_io && r_we) nlp[r_addr[1:0]] = 1'b1;
    if (l_io && l_we) nrp[l_addr[1:0]] = 1'b1;
    m_lerr = exp_blk(l_req, l_io, l_addr, 1'b0);
    m_rerr = exp_blk(r_req, r_io, r_addr, 1'b1);
    @(posedge clk);
    if (l_ram_cs && l_we) ram[ridx(l_addr)] = l_wdata;
    if (r_ram_cs && r_we) ram[ridx(r_addr)] = r_wdata;
    m_lp = nlp; m_rp = nrp;
    m_sel = {l_b3_give, ~r_b2_give, 2'b10};
    #1;
    check("R3 bank_sel", bank_sel, m_sel);
    check("R2 fixed banks", bank_sel[1:0], 2'b10);
    check("R6 l_own_err", l_own_err, m_lerr);
    check("R6 r_own_err", r_own_err, m_rerr);
    check("R7 l_irq", l_irq, |m_lp);
    check("R7 r_irq", r_irq, |m_rp);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) ram[i] = '0;
    rst_n = 1'b0; r_b2_give = 0; l_b3_give = 0; l_wdata = 0; r_wdata = 0;
    drv(0, 0, 0, 16'h0, 0, 0, 0, 16'h0);
    m_sel = 4'b0110; m_lp = 0; m_rp = 0;
    repeat (3) @(negedge clk);
    check("R1 bank_sel", bank_sel, 4'b0110);
    check("R1 irq", {l_irq, r_irq}, 0);
    check("R1 own_err", {l_own_err, r_own_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // ping-pong exchange
    r_wdata = 16'hA5C3;
    drv(0, 0, 0, 16'h0, 1, 0, 1, 16'hC005); step();     // DSP fills bank 2
    r_b2_give = 1; drv(0, 0, 0, 16'h0, 0, 0, 0, 16'h0); step();
    drv(0, 0, 0, 16'h0, 0, 1, 1, 16'h0002); step();     // mailbox 2 to host
    check("R7 host irq after mb2", l_irq, 1);
    drv(1, 0, 0, 16'hC005, 0, 0, 0, 16'h0); step();
    check("R4 host sees DSP data", ram[ridx(16'hC005)], 16'hA5C3);
    drv(0, 1, 0, 16'h0003, 0, 0, 0, 16'h0); step();     // wrong index read
    check("R8 other index keeps irq", l_irq, 1);
    drv(0, 1, 0, 16'h0002, 0, 0, 0, 16'h0); step();
    check("R8 host read clears", l_irq, 0);
    l_wdata = 16'h3C7E;
    drv(1, 0, 1, 16'hE009, 0, 0, 0, 16'h0); step();     // host fills bank 3
    l_b3_give = 1; drv(0, 0, 0, 16'h0, 0, 0, 0, 16'h0); step();
    drv(0, 1, 1, 16'h0003, 0, 0, 0, 16'h0); step();     // mailbox 3 to DSP
    check("R7 DSP irq after mb3", r_irq, 1);
    drv(0, 0, 0, 16'h0, 0, 1, 0, 16'h0003); step();
    check("R8 DSP read clears", r_irq, 0);
    r_wdata = 16'h0F1E;
    drv(1, 0, 0, 16'hE009, 1, 0, 1, 16'hE009); step();  // host now blocked
    check("R6 host blocked on bank 3", l_own_err, 1);
    check("R4 DSP reply stored", ram[ridx(16'hE009)], 16'h0F1E);
    drv(0, 0, 0, 16'h0, 0, 1, 1, 16'h0003); step();
    check("R7 host irq after reply", l_irq, 1);
    // set versus clear on the same mailbox
    drv(0, 1, 0, 16'h0003, 0, 1, 1, 16'h0003); step();
    check("R9 set wins over clear", l_irq, 1);
    drv(0, 1, 0, 16'h0003, 0, 0, 0, 16'h0); step();
    check("R8 clear after collision", l_irq, 0);
    // io strobe overrides memory strobe, lower half ignored
    drv(1, 1, 0, 16'h8001, 1, 1, 0, 16'hA000); step();
    check("R5 io masks cs", {l_ram_cs, r_ram_cs}, 0);
    drv(1, 0, 1, 16'h6000, 1, 0, 1, 16'h0000); step();
    check("R10 no err low half", {l_own_err, r_own_err}, 0);

    for (int n = 0; n < 1500; n++) begin
      logic [15:0] la, ra;
      la = 16'($urandom); ra = 16'($urandom);
      if ($urandom % 4 != 0) begin la[15] = 1; ra[15] = 1; end
      if ($urandom % 8 == 0) r_b2_give = ~r_b2_give;
      if ($urandom % 8 == 0) l_b3_give = ~l_b3_give;
      l_wdata = 16'($urandom); r_wdata = 16'($urandom);
      drv(1'($urandom), ($urandom % 3 == 0), 1'($urandom), la,
          1'($urandom), ($urandom % 3 == 0), 1'($urandom), ra);
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule